// File: doc/BRIEF.md
# Double-Buffered DMA Request Channel

This block sequences word transfers from a local source read port to a destination write port. It has two descriptor slots, and software programs them through a simple register port. Each slot holds a destination word address and a control word. The control word carries an enable flag, a byte-swap flag and a word count. Because there are two slots, software can queue the next request in the idle slot while the engine works on the other one.

For each word, the engine reads the source port and byte-reverses the word if the slot asks for it. It then writes the word to the destination at an address that starts at the programmed word address and grows by four bytes per word. When a slot completes, the engine clears that slot's enable flag and raises a one-cycle done pulse carrying the slot index. Slots take turns: after one slot completes, the other one is considered first.

Top module: `dma_pair_seq`

## Requirements
- R1: The address register of a slot (register index 0 for slot 0, 2 for slot 1) stores write data bits 31:2 and always reads bits 1:0 as zero.
- R2: The control register of a slot (index 1 for slot 0, 3 for slot 1) keeps the enable flag in bit 31, the swap flag in bit 28 and the word count in bits 15:0. All other bits read as zero. Every register resets to zero.
- R3: A slot transfers only when its enable flag is 1 and its count is nonzero. A slot with enable at 0 causes no destination writes.
- R4: When a slot's last word is written, `done` is high for exactly that one cycle with `done_slot` set to the slot index. After that cycle the slot's enable flag reads 0.
- R5: With the swap flag set, the destination data is the source word with its bytes reversed (bits 7:0 go to 31:24, 15:8 to 23:16, and so on). With the flag clear, the data passes unchanged.
- R6: A transfer performs exactly count destination writes, at addresses base, base+4, base+8 and so on. The programmed count still reads back unchanged afterwards.
- R7: A request written to the idle slot while the other slot is running runs after the running one completes. After a completion, the other slot is checked first.
- R8: A slot enabled with a count of zero has its enable cleared without any destination write and without a done pulse.
- R9: Writes to either register of the slot being transferred are ignored. Writes to the other slot take effect.
- R10: `busy` is high in every cycle in which a destination write is issued, and low once no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: bit 1 selects the slot, bit 0 selects address (0) or control (1) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| src_rd | output | 1 | Source read request; data is taken from `src_rdata` in the same cycle |
| src_rdata | input | 32 | Source read data |
| dst_wr | output | 1 | Destination write strobe |
| dst_addr | output | 32 | Destination byte address (word aligned) |
| dst_wdata | output | 32 | Destination write data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_slot | output | 1 | Index of the slot that completed |

## Verification
A wrong word counter appears at the destination port as a missing or extra write. A wrong address pointer appears in the very next write, and a wrong swap flag in the first data word. A slot pointer that selects the wrong slot shows up at the first write of the next transfer, because the address does not match the queued request. An enable flag that is not cleared shows up as a repeated transfer, or as a control read-back with bit 31 still set, within a few cycles of `done`.

// File: rtl/dma_pair_seq.sv
module dma_pair_seq #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        src_rd,
  input  logic [31:0] src_rdata,
  output logic        dst_wr,
  output logic [31:0] dst_addr,
  output logic [31:0] dst_wdata,
  output logic        busy,
  output logic        done,
  output logic        done_slot
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [1:0][29:0]   base_q;
  logic [1:0][CW-1:0] len_q;
  logic [1:0]         en_q, sw_q;
  logic               act_q, cur_q, nxt_q;
  logic [CW-1:0]      cnt_q;
  logic [29:0]        ptr_q;

  logic wslot, wr_ok, cand, idle_go, last;
  logic [31:0] w;

  assign wslot   = reg_addr[1];
  assign wr_ok   = reg_wr && !(act_q && cur_q == wslot);
  assign cand    = en_q[nxt_q] ? nxt_q : ~nxt_q;
  assign idle_go = !act_q && en_q[cand] && !(reg_wr && wslot == cand);
  assign last    = act_q && cnt_q == ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      en_q   <= '0;
      sw_q   <= '0;
      act_q  <= 1'b0;
      cur_q  <= 1'b0;
      nxt_q  <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else begin
      if (wr_ok) begin
        if (!reg_addr[0]) begin
          base_q[wslot] <= reg_wdata[31:2];
        end else begin
          en_q[wslot]  <= reg_wdata[31];
          sw_q[wslot]  <= reg_wdata[28];
          len_q[wslot] <= reg_wdata[CW-1:0];
        end
      end
      if (idle_go) begin
        if (len_q[cand] == '0) begin
          en_q[cand] <= 1'b0;
          nxt_q      <= ~cand;
        end else begin
          act_q <= 1'b1;
          cur_q <= cand;
          cnt_q <= len_q[cand];
          ptr_q <= base_q[cand];
        end
      end
      if (act_q) begin
        ptr_q <= ptr_q + 30'd1;
        cnt_q <= cnt_q - ONE;
        if (last) begin
          act_q       <= 1'b0;
          en_q[cur_q] <= 1'b0;
          nxt_q       <= ~cur_q;
        end
      end
    end
  end

  always_comb begin
    if (!reg_addr[0]) begin
      reg_rdata = {base_q[wslot], 2'b00};
    end else begin
      reg_rdata = '0;
      reg_rdata[31] = en_q[wslot];
      reg_rdata[28] = sw_q[wslot];
      reg_rdata[CW-1:0] = len_q[wslot];
    end
  end

  assign w         = src_rdata;
  assign src_rd    = act_q;
  assign dst_wr    = act_q;
  assign dst_addr  = {ptr_q, 2'b00};
  assign dst_wdata = sw_q[cur_q] ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  assign busy      = act_q;
  assign done      = last;
  assign done_slot = cur_q;

  p_clear_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !en_q[$past(done_slot)]);
  p_single_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr && !done) |=> (dst_wr && dst_addr == $past(dst_addr) + 32'd4));
  p_start_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en_q != 2'b00));
  p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(base_q[cur_q]) && $stable(len_q[cur_q])));
  p_zero_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en_q[cand] && len_q[cand] == '0 && !(reg_wr && wslot == cand)) |=> !busy);
endmodule

// File: tb/dma_pair_seq_tb.sv
module dma_pair_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_rd;
  logic [31:0] src_rdata;
  logic        dst_wr;
  logic [31:0] dst_addr, dst_wdata;
  logic        busy, done, done_slot;

  int tests = 0, fails = 0, cyc = 0;
  int src_k = 0;
  int head = 0, tail = 0, beat = 0;
  logic        q_slot[64];
  logic [31:0] q_base[64];
  int          q_len[64];
  logic        q_sw[64];

  always #2 clk = ~clk;

  dma_pair_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_rd(src_rd),
    .src_rdata(src_rdata), .dst_wr(dst_wr), .dst_addr(dst_addr),
    .dst_wdata(dst_wdata), .busy(busy), .done(done), .done_slot(done_slot)
  );

  function automatic logic [31:0] src_word(int k);
    return (k * 32'h9E3779B9) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] bswap(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  assign src_rdata = src_word(src_k);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (src_rd) src_k <= src_k + 1;
    if (cyc == 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && dst_wr) begin
      chk("R10 busy during write", busy, 1'b1);
      if (head == tail) begin
        chk("R3 unexpected destination write", dst_addr, 32'hxxxx_xxxx);
      end else begin
        chk("R6 destination address", dst_addr, q_base[head % 64] + 32'(4 * beat));
        chk("R5 destination data", dst_wdata,
            q_sw[head % 64] ? bswap(src_word(src_k)) : src_word(src_k));
        beat++;
      end
    end
    if (rst_n && done) begin
      if (head == tail) begin
        chk("R8 unexpected done", 32'(done), 32'd0);
      end else begin
        chk("R7 done slot order", 32'(done_slot), 32'(q_slot[head % 64]));
        chk("R6 word count", beat, q_len[head % 64]);
        head++;
        beat = 0;
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic prog(logic s, logic [31:0] base, logic [31:0] ctrl);
    wr({s, 1'b0}, base);
    if (ctrl[31] && ctrl[15:0] != 16'd0) begin
      q_slot[tail % 64] = s;
      q_base[tail % 64] = {base[31:2], 2'b00};
      q_len[tail % 64]  = int'(ctrl[15:0]);
      q_sw[tail % 64]   = ctrl[28];
      tail++;
    end
    wr({s, 1'b1}, ctrl);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy && head == tail) break;
    end
    repeat (3) @(negedge clk);
    chk("R10 busy low after transfers", busy, 1'b0);
    chk("R6 all queued transfers done", head, tail);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R2 reset value", d, 32'd0);
    end
    chk("R10 reset busy", busy, 1'b0);

    wr(2'd0, 32'h1234_567B);
    rd(2'd0, d);
    chk("R1 address low bits zero", d, 32'h1234_5678);

    wr(2'd3, 32'h7FFF_12AB);
    repeat (10) @(negedge clk);
    chk("R3 disabled slot stays idle", busy, 1'b0);
    rd(2'd3, d);
    chk("R2 reserved bits read zero", d, 32'h1000_12AB);
    wr(2'd3, 32'd0);

    prog(1'b0, 32'h0000_0100, 32'h8000_001E);
    repeat (4) @(negedge clk);
    chk("R10 busy while running", busy, 1'b1);
    wr(2'd0, 32'h0000_FFF0);
    wr(2'd1, 32'h0000_0000);
    rd(2'd0, d);
    chk("R9 write to active address ignored", d, 32'h0000_0100);
    rd(2'd1, d);
    chk("R9 write to active control ignored", d, 32'h8000_001E);
    wait_idle();
    rd(2'd1, d);
    chk("R4 enable cleared, R6 count kept", d, 32'h0000_001E);

    prog(1'b1, 32'h0000_4000, 32'h8000_0000);
    repeat (4) @(negedge clk);
    rd(2'd3, d);
    chk("R8 zero count cleared", d, 32'h0000_0000);
    chk("R8 no transfer for zero count", busy, 1'b0);

    for (int it = 0; it < 40; it++) begin
      logic sa, swa, swb;
      logic [31:0] ca, cb, ba, bb;
      int la, lb;
      sa  = 1'($urandom);
      swa = 1'($urandom);
      swb = 1'($urandom);
      la  = 1 + int'($urandom % 20);
      lb  = (it % 5 == 0) ? 0 : int'($urandom % 13);
      ba  = $urandom;
      bb  = $urandom;
      ca  = 32'h8000_0000 | (32'(swa) << 28) | ($urandom & 32'h6FFF_0000) | 32'(la);
      cb  = 32'h8000_0000 | (32'(swb) << 28) | ($urandom & 32'h6FFF_0000) | 32'(lb);
      prog(sa, ba, ca);
      prog(~sa, bb, cb);
      wait_idle();
      rd({sa, 1'b1}, d);
      chk("R4 first slot enable cleared", d, ca & 32'h1000_FFFF);
      rd({~sa, 1'b1}, d);
      chk("R4 R8 second slot enable cleared", d, cb & 32'h1000_FFFF);
      rd({~sa, 1'b0}, d);
      chk("R1 address readback", d, {bb[31:2], 2'b00});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule